// File: doc/BRIEF.md
# Shared Memory Atomic Unit

This block performs read-modify-write atomic operations on a private scratch memory of 32-bit words. A single request stream delivers an opcode, a base byte address, a 16-bit immediate offset supplied as two bytes, a data operand and a return flag. The unit forms the effective byte address and turns it into a word index. It reads the addressed word and computes the new value, then writes that value back. When the request asks for it, the unit returns the value the memory held before the operation.

The operation set covers add, subtract, increment, decrement, and signed and unsigned minimum and maximum. It also covers the bitwise AND, OR and XOR operations and a 64-bit add over two adjacent words. Two counter operations, append and consume, take their base from the separate `cnt_base` pin instead of the request address. They always return the counter value from before the update.

Requests use a valid/ready handshake. A request is taken on a rising edge where `req_valid` and `req_ready` are both high. The requester must hold its fields stable until that edge. `req_ready` is low only in the cycle that follows an acceptance, which is the read cycle. A new request can therefore be taken while the previous one is writing back, and it reads the freshly written value. The response is a single-cycle `rsp_valid` pulse and has no back-pressure.

Top module: `shm_atomic_unit`

## Requirements
- R1: The effective byte address is base + {req_off1, req_off0}, where req_off1 is the high byte, and wraps modulo 2^32. The word index is bits [11:2] of that address. The two low bits and all bits above bit 11 do not select a word.
- R2: Opcode 0 (add), 1 (subtract: old minus operand), 8 (AND), 9 (OR) and 10 (XOR) replace the word with the result of old OP req_data[31:0], modulo 2^32.
- R3: Opcode 4 (signed min) and 5 (signed max) compare the values as two's complement. Opcode 6 (unsigned min) and 7 (unsigned max) compare them as unsigned. The chosen value is stored.
- R4: Opcode 2 (increment) adds exactly 1 and opcode 3 (decrement) subtracts exactly 1, both modulo 2^32. req_data has no effect on them.
- R5: With req_rtn=1, one rsp_valid pulse carries the pre-operation word in rsp_data[31:0] and zero in rsp_data[63:32]. With req_rtn=0, an atomic opcode produces no pulse but still updates memory.
- R6: Opcode 11 adds req_data[63:0] to the doubleword {word[i+1], word[i]}, where i+1 wraps modulo 1024 and the carry crosses between the halves. The returned value is the full 64-bit old doubleword.
- R7: Opcode 12 (append) adds 1 and opcode 13 (consume) subtracts 1 at the address cnt_base + offset. req_addr has no effect on them. Both always return the previous value, whatever req_rtn is.
- R8: After acceptance on edge E0, req_ready is low for one cycle and then high again. rsp_valid is high in the cycle after edge E2, for one cycle. A request taken on E2 observes the write-back of the previous request.
- R9: Reset leaves req_ready=1 and rsp_valid=0, and every memory word reads zero.
- R10: Opcodes 14 and 15 leave the memory word unchanged and return it when req_rtn=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_op | input | 4 | Operation code |
| req_rtn | input | 1 | Return the old value |
| req_addr | input | 32 | Base byte address for atomic opcodes |
| req_off1 | input | 8 | Offset high byte |
| req_off0 | input | 8 | Offset low byte |
| req_data | input | 64 | Operand; only the low 32 bits are used except by opcode 11 |
| cnt_base | input | 32 | Base byte address for append and consume |
| rsp_valid | output | 1 | Returned value present, one-cycle pulse |
| rsp_data | output | 64 | Returned pre-operation value |

## Verification
The bench issues back-to-back requests to the same word, each taken during the previous request's write-back. A design that read before the write landed would return a stale value there and drift from the model. Several cases target wraparound:
- subtract and decrement past zero, and increment past all ones;
- operands that straddle the sign bit, where mixing signed and unsigned compares selects the wrong value;
- a 64-bit add whose carry must cross into the high word, and one whose high word wraps to index 0.

Addresses are chosen so that low-bit offsets, a high offset byte and bits above the memory span must alias to the same word. Append and consume are issued with req_rtn=0 and a misleading req_addr, so a unit that used the wrong base or suppressed the return is exposed.

// File: rtl/shm_atomic_pkg.sv
package shm_atomic_pkg;

  typedef enum logic [3:0] {
    OP_ADD     = 4'd0,
    OP_SUB     = 4'd1,
    OP_INC     = 4'd2,
    OP_DEC     = 4'd3,
    OP_SMIN    = 4'd4,
    OP_SMAX    = 4'd5,
    OP_UMIN    = 4'd6,
    OP_UMAX    = 4'd7,
    OP_AND     = 4'd8,
    OP_OR      = 4'd9,
    OP_XOR     = 4'd10,
    OP_ADD64   = 4'd11,
    OP_APPEND  = 4'd12,
    OP_CONSUME = 4'd13,
    OP_RSV0    = 4'd14,
    OP_RSV1    = 4'd15
  } shm_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } shm_state_e;

  function automatic logic is_counter_op(input logic [3:0] op);
    return (op == OP_APPEND) || (op == OP_CONSUME);
  endfunction

endpackage

// File: rtl/shm_addr_gen.sv
module shm_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 8,
  parameter int AW     = 10
) (
  input  logic [ADDR_W-1:0] base_atomic,
  input  logic [ADDR_W-1:0] base_counter,
  input  logic              use_counter,
  input  logic [OFF_W-1:0]  off_hi,
  input  logic [OFF_W-1:0]  off_lo,
  output logic [AW-1:0]     word_idx
);
  localparam int OFS_W = 2 * OFF_W;

  logic [ADDR_W-1:0] base_sel;
  logic [ADDR_W-1:0] eff_addr;
  logic              unused_bits;

  assign base_sel    = use_counter ? base_counter : base_atomic;
  assign eff_addr    = base_sel + ADDR_W'({off_hi, off_lo});
  assign word_idx    = eff_addr[AW+1:2];
  assign unused_bits = ^{eff_addr[ADDR_W-1:AW+2], eff_addr[1:0], OFS_W[0]};
endmodule

// File: rtl/shm_atomic_alu.sv
module shm_atomic_alu
  import shm_atomic_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  shm_op_e             op,
  input  logic [DATA_W-1:0]   old_lo,
  input  logic [DATA_W-1:0]   old_hi,
  input  logic [2*DATA_W-1:0] opnd,
  output logic [DATA_W-1:0]   new_lo,
  output logic [DATA_W-1:0]   new_hi,
  output logic                wr_hi
);
  logic [DATA_W-1:0] b;
  logic              s_lt;
  logic              u_lt;

  assign b    = opnd[DATA_W-1:0];
  assign s_lt = $signed(old_lo) < $signed(b);
  assign u_lt = old_lo < b;

  always_comb begin
    new_lo = old_lo;
    new_hi = old_hi;
    wr_hi  = 1'b0;
    case (op)
      OP_ADD:                new_lo = old_lo + b;
      OP_SUB:                new_lo = old_lo - b;
      OP_INC, OP_APPEND:     new_lo = old_lo + DATA_W'(1);
      OP_DEC, OP_CONSUME:    new_lo = old_lo - DATA_W'(1);
      OP_SMIN:               new_lo = s_lt ? old_lo : b;
      OP_SMAX:               new_lo = s_lt ? b : old_lo;
      OP_UMIN:               new_lo = u_lt ? old_lo : b;
      OP_UMAX:               new_lo = u_lt ? b : old_lo;
      OP_AND:                new_lo = old_lo & b;
      OP_OR:                 new_lo = old_lo | b;
      OP_XOR:                new_lo = old_lo ^ b;
      OP_ADD64: begin
        {new_hi, new_lo} = {old_hi, old_lo} + opnd;
        wr_hi            = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/shm_word_store.sv
module shm_word_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  parameter int AW     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     idx,
  output logic [DATA_W-1:0] rd_lo,
  output logic [DATA_W-1:0] rd_hi,
  input  logic              we_lo,
  input  logic              we_hi,
  input  logic [DATA_W-1:0] wd_lo,
  input  logic [DATA_W-1:0] wd_hi
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     idx_nx;

  assign idx_nx = idx + AW'(1);
  assign rd_lo  = mem[idx];
  assign rd_hi  = mem[idx_nx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else begin
      if (we_lo) mem[idx]    <= wd_lo;
      if (we_hi) mem[idx_nx] <= wd_hi;
    end
  end
endmodule

// File: rtl/shm_atomic_unit.sv
module shm_atomic_unit
  import shm_atomic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [3:0]          req_op,
  input  logic                req_rtn,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [OFF_W-1:0]    req_off1,
  input  logic [OFF_W-1:0]    req_off0,
  input  logic [2*DATA_W-1:0] req_data,
  input  logic [ADDR_W-1:0]   cnt_base,
  output logic                rsp_valid,
  output logic [2*DATA_W-1:0] rsp_data
);
  localparam int AW = $clog2(DEPTH);

  shm_state_e          state_q;
  shm_op_e             op_q;
  logic                rtn_q;
  logic [AW-1:0]       idx_q;
  logic [2*DATA_W-1:0] data_q;
  logic [DATA_W-1:0]   old_lo_q, old_hi_q;
  logic [AW-1:0]       idx_d;
  logic [DATA_W-1:0]   rd_lo, rd_hi, new_lo, new_hi;
  logic                wr_hi, accept;

  assign req_ready = (state_q != ST_RD);
  assign accept    = req_valid && req_ready;

  shm_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .AW(AW)) u_addr (
    .base_atomic (req_addr),
    .base_counter(cnt_base),
    .use_counter (is_counter_op(req_op)),
    .off_hi      (req_off1),
    .off_lo      (req_off0),
    .word_idx    (idx_d)
  );

  shm_atomic_alu #(.DATA_W(DATA_W)) u_alu (
    .op    (op_q),
    .old_lo(old_lo_q),
    .old_hi(old_hi_q),
    .opnd  (data_q),
    .new_lo(new_lo),
    .new_hi(new_hi),
    .wr_hi (wr_hi)
  );

  shm_word_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk  (clk),
    .rst  (rst),
    .idx  (idx_q),
    .rd_lo(rd_lo),
    .rd_hi(rd_hi),
    .we_lo(state_q == ST_WR),
    .we_hi((state_q == ST_WR) && wr_hi),
    .wd_lo(new_lo),
    .wd_hi(new_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      op_q      <= OP_ADD;
      rtn_q     <= 1'b0;
      idx_q     <= '0;
      data_q    <= '0;
      old_lo_q  <= '0;
      old_hi_q  <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) state_q <= ST_RD;
        ST_RD: begin
          old_lo_q <= rd_lo;
          old_hi_q <= rd_hi;
          state_q  <= ST_WR;
        end
        ST_WR: begin
          rsp_valid <= rtn_q || is_counter_op(op_q);
          rsp_data  <= (op_q == OP_ADD64) ? {old_hi_q, old_lo_q}
                                          : {{DATA_W{1'b0}}, old_lo_q};
          state_q   <= accept ? ST_RD : ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (accept) begin
        op_q   <= shm_op_e'(req_op);
        rtn_q  <= req_rtn;
        idx_q  <= idx_d;
        data_q <= req_data;
      end
    end
  end
endmodule

// File: rtl/shm_atomic_unit_chk.sv
module shm_atomic_unit_chk
  import shm_atomic_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [3:0]        req_op,
  input logic              req_rtn,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_hi
);
  logic acc;
  assign acc = req_valid && req_ready;

  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    acc |=> !req_ready); // R8
  AST_READY_BACK: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> req_ready); // R8
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R8
  AST_RSP_DUE: assert property (@(posedge clk) disable iff (rst)
    (acc && req_rtn && !is_counter_op(req_op)) |=> ##2 rsp_valid); // R5
  AST_RSP_NONE: assert property (@(posedge clk) disable iff (rst)
    (acc && !req_rtn && !is_counter_op(req_op)) |=> ##2 !rsp_valid); // R5
  AST_CNT_RSP: assert property (@(posedge clk) disable iff (rst)
    (acc && is_counter_op(req_op)) |=> ##2 rsp_valid); // R7
  AST_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && ($past(req_op, 3) != OP_ADD64)) |-> (rsp_hi == '0)); // R5
endmodule

bind shm_atomic_unit shm_atomic_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_op   (req_op),
  .req_rtn  (req_rtn),
  .rsp_valid(rsp_valid),
  .rsp_hi   (rsp_data[2*DATA_W-1:DATA_W])
);

// File: tb/shm_atomic_unit_bench.sv
module shm_atomic_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_op = '0;
  logic        req_rtn = 1'b0;
  logic [31:0] req_addr = '0;
  logic [7:0]  req_off1 = '0;
  logic [7:0]  req_off0 = '0;
  logic [63:0] req_data = '0;
  logic [31:0] cnt_base = '0;
  logic        rsp_valid;
  logic [63:0] rsp_data;

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  int    last_acc = -1;
  string cur_tag = "R9";
  bit [31:0] mem_m [1024];
  int        q_cyc [$];
  bit [63:0] q_dat [$];
  string     q_tag [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  shm_atomic_unit u_shm_atomic_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_rtn(req_rtn), .req_addr(req_addr),
    .req_off1(req_off1), .req_off0(req_off0), .req_data(req_data),
    .cnt_base(cnt_base), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  task automatic check(input string tag, input bit ok, input bit [63:0] act, input bit [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  // Behavioural reference: applies each accepted request in order.
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int w = 0; w < 1024; w++) mem_m[w] = 32'h0;
      last_acc = -1;
    end else if (req_valid && req_ready) begin
      bit [31:0] ea, a, b, oh;
      int i, j;
      bit cnt;
      cnt = (req_op == 4'd12) || (req_op == 4'd13);
      ea = (cnt ? cnt_base : req_addr) + {16'h0, req_off1, req_off0};
      i = int'(ea[11:2]);
      j = (i + 1) % 1024;
      a = mem_m[i]; oh = mem_m[j]; b = req_data[31:0];
      case (req_op)
        4'd0:  mem_m[i] = a + b;
        4'd1:  mem_m[i] = a - b;
        4'd2, 4'd12: mem_m[i] = a + 1;
        4'd3, 4'd13: mem_m[i] = a - 1;
        4'd4:  mem_m[i] = ($signed(a) < $signed(b)) ? a : b;
        4'd5:  mem_m[i] = ($signed(a) > $signed(b)) ? a : b;
        4'd6:  mem_m[i] = (a < b) ? a : b;
        4'd7:  mem_m[i] = (a > b) ? a : b;
        4'd8:  mem_m[i] = a & b;
        4'd9:  mem_m[i] = a | b;
        4'd10: mem_m[i] = a ^ b;
        4'd11: {mem_m[j], mem_m[i]} = {oh, a} + req_data;
        default: ;
      endcase
      if (req_rtn || cnt) begin
        q_cyc.push_back(cyc + 2);
        q_dat.push_back(req_op == 4'd11 ? {oh, a} : {32'h0, a});
        q_tag.push_back(cur_tag);
      end
      last_acc = cyc;
    end
  end

  // Per-cycle comparison against the reference.
  always @(negedge clk) begin
    if (!rst) begin
      check("R8 ready", req_ready == (cyc != last_acc), {63'h0, req_ready}, {63'h0, cyc != last_acc});
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        check(q_tag[0], rsp_valid && rsp_data == q_dat[0], rsp_data, q_dat[0]);
        void'(q_cyc.pop_front()); void'(q_dat.pop_front()); void'(q_tag.pop_front());
      end else begin
        check("R5 no-response", !rsp_valid, {63'h0, rsp_valid}, 64'h0);
      end
    end
  end

  task automatic issue(input logic [3:0] op, input logic [31:0] base, input logic [7:0] o1,
                       input logic [7:0] o0, input logic [63:0] d, input logic rtn, input string tag);
    @(negedge clk);
    req_op = op; req_addr = base; req_off1 = o1; req_off0 = o0;
    req_data = d; req_rtn = rtn; cur_tag = tag; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic rd(input logic [31:0] base, input string tag);
    issue(4'd9, base, 8'h0, 8'h0, 64'h0, 1'b1, tag);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset ready", req_ready == 1'b1, {63'h0, req_ready}, 64'h1);
    check("R9 reset rsp", rsp_valid == 1'b0, {63'h0, rsp_valid}, 64'h0);
    rst = 1'b0;
    rd(32'h40, "R9 zero after reset");
    rd(32'hFFC, "R9 zero top word");
    issue(4'd0, 32'h40, 0, 0, 64'd5, 1, "R2 add rtn");
    issue(4'd0, 32'h40, 0, 0, 64'd7, 0, "R5 add no rtn");
    rd(32'h40, "R5 update without return");
    issue(4'd1, 32'h40, 0, 0, 64'd13, 1, "R2 sub wrap");
    rd(32'h40, "R2 sub result");
    issue(4'd2, 32'h40, 0, 0, 64'hDEAD, 1, "R4 inc wrap");
    issue(4'd3, 32'h40, 0, 0, 64'h1234, 1, "R4 dec wrap");
    issue(4'd2, 32'h40, 0, 0, 64'h0, 1, "R4 inc back");
    rd(32'h40, "R4 result");
    // R1: aliasing addresses
    issue(4'd0, 32'h100, 8'h01, 8'h04, 64'hA5, 1, "R1 offset bytes");
    rd(32'h207, "R1 low bits ignored");
    rd(32'h1204, "R1 high bits ignored");
    issue(4'd0, 32'hFFFF_FFFC, 8'h02, 8'h08, 64'h3, 1, "R1 address wrap");
    rd(32'h204, "R1 wrapped word");
    // R3 signed and unsigned comparisons
    issue(4'd8, 32'h80, 0, 0, 64'h0, 0, "R2 and clear");
    issue(4'd9, 32'h80, 0, 0, 64'hFFFF_FFF0, 1, "R2 or set");
    issue(4'd4, 32'h80, 0, 0, 64'd5, 1, "R3 smin");
    rd(32'h80, "R3 smin keeps negative");
    issue(4'd6, 32'h80, 0, 0, 64'd5, 1, "R3 umin");
    rd(32'h80, "R3 umin picks 5");
    issue(4'd5, 32'h80, 0, 0, 64'hFFFF_FF00, 1, "R3 smax");
    rd(32'h80, "R3 smax keeps 5");
    issue(4'd7, 32'h80, 0, 0, 64'hFFFF_FF00, 1, "R3 umax");
    rd(32'h80, "R3 umax result");
    issue(4'd10, 32'h80, 0, 0, 64'h0F0F_0F0F, 1, "R2 xor");
    issue(4'd8, 32'h80, 0, 0, 64'h00FF_FF00, 1, "R2 and");
    rd(32'h80, "R2 logic result");
    // R6 64-bit add with carry and index wrap
    issue(4'd9, 32'h28, 0, 0, 64'hFFFF_FFFF, 0, "R6 set lo");
    issue(4'd0, 32'h2C, 0, 0, 64'h1, 0, "R6 set hi");
    issue(4'd11, 32'h28, 0, 0, 64'h1, 1, "R6 add64 carry");
    rd(32'h28, "R6 lo after carry");
    rd(32'h2C, "R6 hi after carry");
    issue(4'd9, 32'hFFC, 0, 0, 64'hFFFF_FFFE, 0, "R6 set top");
    issue(4'd11, 32'hFFC, 0, 0, 64'h0000_0002_0000_0003, 1, "R6 add64 wrap");
    rd(32'h0, "R6 high word at index 0");
    rd(32'hFFC, "R6 low word top");
    // R7 counters
    @(negedge clk); cnt_base = 32'h300;
    issue(4'd12, 32'h40, 8'h00, 8'h08, 64'h99, 0, "R7 append");
    issue(4'd12, 32'h40, 8'h00, 8'h08, 64'h99, 0, "R7 append again");
    issue(4'd13, 32'h80, 8'h00, 8'h08, 64'h0, 1, "R7 consume");
    rd(32'h308, "R7 counter word");
    rd(32'h40, "R7 req_addr word untouched");
    issue(4'd13, 32'h0, 8'h00, 8'h0C, 64'h0, 0, "R7 consume wrap");
    rd(32'h30C, "R7 consume result");
    // R10 reserved opcodes
    issue(4'd14, 32'h80, 0, 0, 64'hFFFF, 1, "R10 reserved 14");
    issue(4'd15, 32'h80, 0, 0, 64'hFFFF, 0, "R10 reserved 15");
    rd(32'h80, "R10 unchanged");
    // R8 back-to-back on one word
    for (int k = 0; k < 6; k++) issue(4'd0, 32'h200, 0, 0, 64'(k + 1), 1, "R8 back-to-back");
    rd(32'h200, "R8 accumulated");
    repeat (5) @(negedge clk);
    check("R5 all responses delivered", q_cyc.size() == 0, 64'(q_cyc.size()), 64'h0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=done");
    finish_run();
  end
endmodule